// File: doc/BRIEF.md
# Vector Length Control Registers

This block keeps the vector-length control state of a processor core: the ceiling on vector length (`maxLen`), the active vector length (`curLen`), and two element offsets, one for sources and one for destinations. A CSR instruction presents an address, an enable, and either a full-width source operand or a 5-bit immediate. The block updates its state on the next rising clock edge and returns a read value to the instruction in the same cycle.

Lengths are always clamped. The ceiling can never exceed 64, the XLEN width. The active length can never exceed the current ceiling when it is written. A write of zero to either length is rejected and raises a one-cycle flag. A 5-bit immediate aimed at either length register is biased by one, so lengths 1 to 32 can be reached without a source register. A packed state register lets a single write load all four values. Its length fields carry the same bias, and the offsets are clamped against the freshly written length.

Top module: `vlen_ctrl`

## Requirements
- R1: After reset, `maxLen` and `curLen` are 1, both offsets are 0, and `illegalVal` is 0.
- R2: A source-operand write to the MVL address stores min(operand, 64), comparing the whole XLEN-wide operand.
- R3: A source-operand write to the VL address stores min(operand, current `maxLen`). It does not change `maxLen`.
- R4: An immediate write to the MVL or VL address uses immediate+1 as the written value, then applies the R2/R3 clamp.
- R5: An immediate write to the packed state address uses the immediate unbiased as the packed operand.
- R6: For an immediate write to MVL or VL, `csrRdData` shows the register value after that write.
- R7: For every other access (any source-operand write, an immediate write to the state address, or no write at all), `csrRdData` shows the addressed value before the write.
- R8: A write to the state address sets `maxLen` to operand[4:0]+1 (clamped to 64). It then sets `curLen` to min(operand[10:6]+1, new `maxLen`). Bits 5 and 11 are ignored.
- R9: The same state write sets the source offset to min(operand[16:12], new `curLen`-1) and the destination offset to min(operand[22:18], new `curLen`-1).
- R10: A write whose value is zero to MVL or VL leaves every register unchanged. `illegalVal` is then 1 for exactly the cycle after that edge.
- R11: Reading the state address returns `maxLen`-1 in bits 5:0, `curLen`-1 in bits 11:6, the source offset in bits 17:12 and the destination offset in bits 23:18. All other bits are 0.
- R12: An access to any address other than the three owned ones changes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Write request this cycle |
| csrUseImm | input | 1 | 1: immediate form, 0: source-operand form |
| csrAddr | input | 12 | CSR address |
| csrSrc | input | XLEN | Source-operand value |
| csrImm | input | 5 | Immediate value |
| csrRdData | output | XLEN | Read value returned to the instruction |
| illegalVal | output | 1 | One-cycle zero-length rejection flag |
| maxLen | output | 7 | Current length ceiling |
| curLen | output | 7 | Current vector length |
| srcOffs | output | 6 | Source element offset |
| dstOffs | output | 6 | Destination element offset |

## Verification
The bench drives source-operand values far above 64, including values that exceed 64 only in their upper 32 bits. A design that truncated the operand before clamping would store a small length instead of 64. It also writes VL above a lowered ceiling, writes packed states whose length field exceeds the ceiling field, and writes offset fields larger than the new length. A design that clamped offsets against the old length, or set VL before MVL, would keep stale values. Immediate writes to the lengths, to the state address and to unowned addresses check both the bias and whether the read returns the old or the new value. Zero writes check that the state stays put and that the flag lasts only one cycle.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  // width of each packed-state field and of the usable part of it
  localparam int FIELD_W = 6;
  localparam int IMM_W   = 5;

  // bit positions inside the packed state word (decoded by software)
  localparam int POS_MVL = 0;
  localparam int POS_VL  = 6;
  localparam int POS_SRC = 12;
  localparam int POS_DST = 18;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_MVL   = 2'd1,
    SEL_VL    = 2'd2,
    SEL_STATE = 2'd3
  } csrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    ldMvl;
    logic    ldVl;
    logic    ldState;
    logic    retNew;
    csrSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/vlen_ctrl_ctl.sv
module vlen_ctrl_ctl
  import vlen_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter logic [11:0] ADDR_MVL   = 12'h4C0,
  parameter logic [11:0] ADDR_VL    = 12'h4C1,
  parameter logic [11:0] ADDR_STATE = 12'h4C2
) (
  input  logic             wrEn,
  input  logic             useImm,
  input  logic [11:0]      addr,
  input  logic [XLEN-1:0]  srcVal,
  input  logic [IMM_W-1:0] immVal,
  output strobe_t          stb,
  output logic [XLEN-1:0]  operand
);

  csrSel_e sel;
  logic    isLen;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] immBiased;

  always_comb begin
    if (addr == ADDR_MVL)        sel = SEL_MVL;
    else if (addr == ADDR_VL)    sel = SEL_VL;
    else if (addr == ADDR_STATE) sel = SEL_STATE;
    else                         sel = SEL_NONE;
  end

  assign isLen     = (sel == SEL_MVL) || (sel == SEL_VL);
  assign immExt    = XLEN'(immVal);
  assign immBiased = immExt + XLEN'(1);

  always_comb begin
    if (!useImm)     operand = srcVal;
    else if (isLen)  operand = immBiased;
    else             operand = immExt;
  end

  always_comb begin
    stb         = '0;
    stb.rdSel   = sel;
    stb.ldMvl   = wrEn && (sel == SEL_MVL);
    stb.ldVl    = wrEn && (sel == SEL_VL);
    stb.ldState = wrEn && (sel == SEL_STATE);
    stb.retNew  = wrEn && useImm && isLen;
  end

endmodule

// File: rtl/vlen_ctrl_dp.sv
module vlen_ctrl_dp
  import vlen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MAXVL = 64,
  localparam int LW   = $clog2(MAXVL + 1),
  localparam int OW   = $clog2(MAXVL)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [XLEN-1:0] operand,
  output logic [LW-1:0]   mvl,
  output logic [LW-1:0]   vl,
  output logic [OW-1:0]   srcOffs,
  output logic [OW-1:0]   dstOffs,
  output logic [XLEN-1:0] rdData,
  output logic            illegal
);

  localparam logic [LW-1:0] CEIL = LW'(MAXVL);

  logic            opZero;
  logic [LW-1:0]   mvlFromOp, vlFromOp;
  logic [LW-1:0]   fMvl, fVl, stMvl, stVl, stVlM1;
  logic [LW-1:0]   fSrc, fDst;
  logic [OW-1:0]   stSrc, stDst;
  logic [LW-1:0]   mvlNxt, vlNxt;
  logic [OW-1:0]   srcNxt, dstNxt;
  logic            illegalNxt;
  logic [XLEN-1:0] curRead, newRead;

  assign opZero = (operand == '0);

  // plain length writes, compared on the full operand width
  assign mvlFromOp = (operand > XLEN'(MAXVL)) ? CEIL : operand[LW-1:0];
  assign vlFromOp  = (operand > XLEN'(mvl))   ? mvl  : operand[LW-1:0];

  // packed state fan-out: MVL first, then VL, then offsets against new VL
  assign fMvl   = LW'(operand[POS_MVL +: IMM_W]) + LW'(1);
  assign fVl    = LW'(operand[POS_VL  +: IMM_W]) + LW'(1);
  assign fSrc   = LW'(operand[POS_SRC +: IMM_W]);
  assign fDst   = LW'(operand[POS_DST +: IMM_W]);
  assign stMvl  = (fMvl > CEIL)  ? CEIL  : fMvl;
  assign stVl   = (fVl  > stMvl) ? stMvl : fVl;
  assign stVlM1 = stVl - LW'(1);
  assign stSrc  = (fSrc > stVlM1) ? stVlM1[OW-1:0] : fSrc[OW-1:0];
  assign stDst  = (fDst > stVlM1) ? stVlM1[OW-1:0] : fDst[OW-1:0];

  always_comb begin
    mvlNxt     = mvl;
    vlNxt      = vl;
    srcNxt     = srcOffs;
    dstNxt     = dstOffs;
    illegalNxt = 1'b0;
    if (stb.ldState) begin
      mvlNxt = stMvl;
      vlNxt  = stVl;
      srcNxt = stSrc;
      dstNxt = stDst;
    end else if (stb.ldMvl) begin
      if (opZero) illegalNxt = 1'b1;
      else        mvlNxt     = mvlFromOp;
    end else if (stb.ldVl) begin
      if (opZero) illegalNxt = 1'b1;
      else        vlNxt      = vlFromOp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mvl     <= LW'(1);
      vl      <= LW'(1);
      srcOffs <= '0;
      dstOffs <= '0;
      illegal <= 1'b0;
    end else begin
      mvl     <= mvlNxt;
      vl      <= vlNxt;
      srcOffs <= srcNxt;
      dstOffs <= dstNxt;
      illegal <= illegalNxt;
    end
  end

  function automatic logic [XLEN-1:0] readOf(
    input csrSel_e       s,
    input logic [LW-1:0] m,
    input logic [LW-1:0] v,
    input logic [OW-1:0] so,
    input logic [OW-1:0] d
  );
    logic [XLEN-1:0] r;
    logic [LW-1:0]   mm1, vm1;
    r   = '0;
    mm1 = m - LW'(1);
    vm1 = v - LW'(1);
    case (s)
      SEL_MVL: r = XLEN'(m);
      SEL_VL:  r = XLEN'(v);
      SEL_STATE: begin
        r[POS_MVL +: FIELD_W] = FIELD_W'(mm1);
        r[POS_VL  +: FIELD_W] = FIELD_W'(vm1);
        r[POS_SRC +: FIELD_W] = FIELD_W'(so);
        r[POS_DST +: FIELD_W] = FIELD_W'(d);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  assign curRead = readOf(stb.rdSel, mvl, vl, srcOffs, dstOffs);
  assign newRead = readOf(stb.rdSel, mvlNxt, vlNxt, srcNxt, dstNxt);
  assign rdData  = stb.retNew ? newRead : curRead;

endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          MAXVL      = 64,
  parameter logic [11:0] ADDR_MVL   = 12'h4C0,
  parameter logic [11:0] ADDR_VL    = 12'h4C1,
  parameter logic [11:0] ADDR_STATE = 12'h4C2,
  localparam int LW = $clog2(MAXVL + 1),
  localparam int OW = $clog2(MAXVL)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWrEn,
  input  logic            csrUseImm,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrSrc,
  input  logic [4:0]      csrImm,
  output logic [XLEN-1:0] csrRdData,
  output logic            illegalVal,
  output logic [LW-1:0]   maxLen,
  output logic [LW-1:0]   curLen,
  output logic [OW-1:0]   srcOffs,
  output logic [OW-1:0]   dstOffs
);

  strobe_t         stb;
  logic [XLEN-1:0] operand;

  vlen_ctrl_ctl #(
    .XLEN(XLEN), .ADDR_MVL(ADDR_MVL), .ADDR_VL(ADDR_VL), .ADDR_STATE(ADDR_STATE)
  ) u_ctl (
    .wrEn(csrWrEn), .useImm(csrUseImm), .addr(csrAddr),
    .srcVal(csrSrc), .immVal(csrImm), .stb(stb), .operand(operand)
  );

  vlen_ctrl_dp #(.XLEN(XLEN), .MAXVL(MAXVL)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .operand(operand),
    .mvl(maxLen), .vl(curLen), .srcOffs(srcOffs), .dstOffs(dstOffs),
    .rdData(csrRdData), .illegal(illegalVal)
  );

endmodule

// File: rtl/vlen_ctrl_chk.sv
module vlen_ctrl_chk #(
  parameter int          XLEN       = 64,
  parameter int          MAXVL      = 64,
  parameter logic [11:0] ADDR_MVL   = 12'h4C0,
  parameter logic [11:0] ADDR_VL    = 12'h4C1,
  parameter logic [11:0] ADDR_STATE = 12'h4C2,
  localparam int LW = $clog2(MAXVL + 1),
  localparam int OW = $clog2(MAXVL)
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrWrEn,
  input logic            csrUseImm,
  input logic [11:0]     csrAddr,
  input logic [XLEN-1:0] csrSrc,
  input logic [4:0]      csrImm,
  input logic            illegalVal,
  input logic [LW-1:0]   maxLen,
  input logic [LW-1:0]   curLen,
  input logic [OW-1:0]   srcOffs,
  input logic [OW-1:0]   dstOffs
);

  logic stWr, zeroMvlWr, unowned;
  assign stWr      = csrWrEn && (csrAddr == ADDR_STATE);
  assign zeroMvlWr = csrWrEn && !csrUseImm && (csrAddr == ADDR_MVL) && (csrSrc == '0);
  assign unowned   = (csrAddr != ADDR_MVL) && (csrAddr != ADDR_VL) && (csrAddr != ADDR_STATE);

  // R2
  mvl_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maxLen != '0) && (maxLen <= LW'(MAXVL)));

  // R8
  state_mvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !csrUseImm && csrSrc[4:0] < 5'd31) |=> (maxLen == LW'($past(csrSrc[4:0])) + LW'(1)));

  // R9
  state_offs_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWr |=> ((LW'(srcOffs) < curLen) && (LW'(dstOffs) < curLen)));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroMvlWr |=> illegalVal);

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroMvlWr |=> ($stable(maxLen) && $stable(curLen)));

  // R12
  unowned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && unowned) |=> ($stable(maxLen) && $stable(curLen) && $stable(srcOffs) && $stable(dstOffs)));

endmodule

bind vlen_ctrl vlen_ctrl_chk #(
  .XLEN(XLEN), .MAXVL(MAXVL), .ADDR_MVL(ADDR_MVL), .ADDR_VL(ADDR_VL), .ADDR_STATE(ADDR_STATE)
) u_chk (
  .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrUseImm(csrUseImm), .csrAddr(csrAddr),
  .csrSrc(csrSrc), .csrImm(csrImm), .illegalVal(illegalVal), .maxLen(maxLen),
  .curLen(curLen), .srcOffs(srcOffs), .dstOffs(dstOffs)
);

// File: tb/test_vlen_ctrl.sv
module test_vlen_ctrl;

  localparam logic [11:0] A_MVL = 12'h4C0;
  localparam logic [11:0] A_VL  = 12'h4C1;
  localparam logic [11:0] A_ST  = 12'h4C2;
  localparam logic [11:0] A_OTH = 12'h300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic        csrUseImm = 1'b0;
  logic [11:0] csrAddr = 12'h0;
  logic [63:0] csrSrc = '0;
  logic [4:0]  csrImm = '0;
  logic [63:0] csrRdData;
  logic        illegalVal;
  logic [6:0]  maxLen, curLen;
  logic [5:0]  srcOffs, dstOffs;

  int total = 0;
  int bad   = 0;

  // reference state
  longint unsigned mM = 1, mV = 1, mS = 0, mD = 0;
  bit mIll = 0;

  always #2.5 clk = ~clk;

  vlen_ctrl i_vlen_ctrl (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrUseImm(csrUseImm),
    .csrAddr(csrAddr), .csrSrc(csrSrc), .csrImm(csrImm), .csrRdData(csrRdData),
    .illegalVal(illegalVal), .maxLen(maxLen), .curLen(curLen),
    .srcOffs(srcOffs), .dstOffs(dstOffs)
  );

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned umin(longint unsigned a, longint unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic longint unsigned packed_read();
    return (mD << 18) | (mS << 12) | ((mV - 1) << 6) | (mM - 1);
  endfunction

  function automatic longint unsigned cur_read(logic [11:0] a);
    if (a == A_MVL) return mM;
    if (a == A_VL)  return mV;
    if (a == A_ST)  return packed_read();
    return 0;
  endfunction

  task automatic compare_state(string req);
    check(req, "maxLen", maxLen, mM);
    check(req, "curLen", curLen, mV);
    check(req, "srcOffs", srcOffs, mS);
    check(req, "dstOffs", dstOffs, mD);
    check(req, "illegalVal", illegalVal, mIll);
  endtask

  // one access: drive at negedge, check read, clock, check state
  task automatic access(string req, bit we, bit imm, logic [11:0] a,
                        longint unsigned src, logic [4:0] iv);
    longint unsigned val, expRd, fm, fv;
    @(negedge clk);
    csrWrEn = we; csrUseImm = imm; csrAddr = a; csrSrc = src; csrImm = iv;
    #1;
    expRd = cur_read(a);
    mIll = 0;
    if (we) begin
      if (a == A_MVL || a == A_VL) begin
        val = imm ? longint'(iv) + 1 : src;
        if (val == 0) mIll = 1;
        else if (a == A_MVL) mM = umin(val, 64);
        else mV = umin(val, mM);
        if (imm) expRd = cur_read(a);
      end else if (a == A_ST) begin
        val = imm ? longint'(iv) : src;
        fm = (val & 31) + 1;
        fv = ((val >> 6) & 31) + 1;
        mM = umin(fm, 64);
        mV = umin(fv, mM);
        mS = umin((val >> 12) & 31, mV - 1);
        mD = umin((val >> 18) & 31, mV - 1);
      end
    end
    check(req, "csrRdData", csrRdData, expRd);
    @(posedge clk);
    #1;
    compare_state(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset values
    compare_state("R1");
    access("R1", 0, 0, A_ST, 0, 0);                       // packed read of reset state

    access("R2", 1, 0, A_MVL, 64'd40, 0);
    access("R2", 1, 0, A_MVL, 64'd1000, 0);              // clamps to 64
    access("R2", 1, 0, A_MVL, 64'h1_0000_0003, 0);       // high bits matter
    access("R3", 1, 0, A_VL, 64'd70, 0);                 // clamps to ceiling
    access("R2", 1, 0, A_MVL, 64'd10, 0);
    access("R3", 1, 0, A_VL, 64'd12, 0);                 // clamps to 10
    access("R3", 1, 0, A_VL, 64'd7, 0);
    access("R4", 1, 1, A_MVL, 0, 5'd31);                 // MVL=32, R6 returns new
    access("R6", 1, 1, A_VL, 0, 5'd0);                   // VL=1, returns 1
    access("R6", 1, 1, A_VL, 0, 5'd20);                  // VL=21
    access("R4", 1, 1, A_MVL, 0, 5'd4);                  // MVL=5, VL stays 21
    access("R6", 1, 1, A_VL, 0, 5'd9);                   // min(10,5)=5
    access("R7", 1, 0, A_MVL, 64'd50, 0);                // returns old 5
    access("R5", 1, 1, A_ST, 0, 5'd17);                  // MVL=18, VL=1, offs 0
    access("R8", 1, 0, A_ST, (64'd3 << 6) | 64'd2 | (64'd1 << 5) | (64'd1 << 11), 0);
    access("R8", 1, 0, A_ST, (64'd31 << 6) | 64'd7, 0);  // VL clamped to 8
    access("R9", 1, 0, A_ST, (64'd30 << 18) | (64'd2 << 12) | (64'd4 << 6) | 64'd15, 0);
    access("R9", 1, 0, A_ST, (64'd31 << 18) | (64'd31 << 12) | (64'd31 << 6) | 64'd31, 0);
    access("R11", 0, 0, A_ST, 0, 0);
    access("R7", 0, 0, A_VL, 0, 0);
    access("R10", 1, 0, A_MVL, 64'd0, 0);
    access("R10", 0, 0, A_MVL, 0, 0);                    // flag drops
    access("R10", 1, 0, A_VL, 64'd0, 0);
    access("R10", 1, 0, A_VL, 64'd0, 0);
    access("R12", 1, 0, A_OTH, 64'hFFFF, 0);
    access("R12", 1, 1, A_OTH, 0, 5'd3);

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      longint unsigned s;
      int pick = $urandom_range(0, 4);
      a = (pick == 0) ? A_MVL : (pick == 1) ? A_VL : (pick == 2) ? A_ST :
          (pick == 3) ? A_MVL : A_OTH;
      s = ($urandom_range(0, 3) == 0) ? {$urandom(), $urandom()} : longint'($urandom_range(0, 80));
      if ($urandom_range(0, 7) == 0) s = 0;
      access("R7", $urandom_range(0, 5) != 0, $urandom_range(0, 1), a, s, 5'($urandom_range(0, 31)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule